// File: doc/BRIEF.md
# RBW Gear Decimation Controller

This block sits beside the decimation chain of a digital IF receiver. It takes a resolution-bandwidth gear number and produces everything the chain needs for that gear:
- the comb-integrator (CIC) decimation factor;
- how many of the cascaded half-band decimate-by-2 stages are in use, with an enable for each stage;
- the number of low bits to drop after the CIC.

The eight gears step in a 1-3-10 pattern from 3 MHz (gear 0) down to 1 kHz (gear 7). For each gear the total decimation approximates the 100 MSPS input rate divided by five times the bandwidth. The CIC takes the whole ratio for the widest gears. Narrower gears hand a factor of 8 or 32 to the half-band cascade, and the CIC rounds off the rest.

When a different gear is presented, the controller does the following:
1. It holds the chain in reset for a fixed flush window.
2. It keeps the old settings on its outputs during that window.
3. It swaps in the new settings in the same cycle that it raises the configuration-valid flag.

Because of this sequence, no sample mixing two rates leaves the chain. A small monitor compares the product of the applied factors with the ideal ratio for the applied gear and raises an error flag when the rounding is out of tolerance.

Top module: `rbw_decim_ctrl`

## Requirements
- R1: During reset and until the start-up flush ends, `chain_rst` is 1 and `cfg_valid` is 0, and the settings are those of gear 0. `cfg_valid` rises, with `chain_rst` low, 16 cycles after the first clock edge with reset low.
- R2: Gears 0, 1 and 2 (3 MHz, 1 MHz, 300 kHz) apply CIC factors 7, 20 and 67 with zero half-band stages, so `hb_en` is 00000.
- R3: Gears 3, 4 and 5 (100 kHz, 30 kHz, 10 kHz) apply CIC factors 25, 83 and 250 with three half-band stages. `hb_en` is 00111, where bit i enables stage i and stage 0 is first in the chain.
- R4: Gears 6 and 7 (3 kHz, 1 kHz) apply CIC factors 208 and 625 with five half-band stages, so `hb_en` is 11111.
- R5: `cic_shift` equals 5 times ceil(log2(CIC factor)). Per gear this gives 15, 25, 35, 25, 35, 40, 40 and 50.
- R6: A gear input above 7 is treated as gear 7. Moving between two input codes that both map to the gear already applied causes no flush.
- R7: Take the clock edge that samples a new gear value. `chain_rst` rises 2 cycles after that edge and stays high for exactly 16 cycles. `cfg_valid` is low over the same window and returns high 18 cycles after that edge.
- R8: While the chain is held in reset, the outputs keep the previous gear's settings. While `cfg_valid` stays high, the settings do not change.
- R9: If another gear value is sampled before the window would end, the 16-cycle count restarts from that sample. `chain_rst` stays high without a gap. Only the last gear is applied. The window ends when its count expires, so a value sampled one cycle before `cfg_valid` would return gets its own later flush.
- R10: `rate_err` stays 0 for every gear. It would rise one cycle after a valid configuration whose CIC factor times 2^stages differs from 100e6 / (5 × bandwidth) by more than 2^stages / 2.
- R11: Presenting the gear that is already applied causes no flush: `chain_rst` stays 0 and `cfg_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gear_in | input | 4 | Requested bandwidth gear; codes above 7 map to 7 |
| cic_rate | output | 10 | CIC decimation factor |
| hb_stages | output | 3 | Number of active half-band stages (0, 3 or 5) |
| hb_en | output | 5 | Per-stage enable; bit i drives stage i, a 0 bypasses it |
| cic_shift | output | 6 | Low bits dropped after the CIC |
| chain_rst | output | 1 | Holds the decimation chain in reset |
| cfg_valid | output | 1 | Settings are applied and stable |
| rate_err | output | 1 | Applied decimation product is out of tolerance |

## Verification
Each result has a fixed due cycle, counted from the clock edge that samples a new gear:
- `chain_rst` is due high 2 cycles after that edge.
- `cfg_valid` and the new settings are due 18 cycles after it.
- `rate_err` follows the applied configuration one cycle later.

For every change, the driver pushes a scoreboard entry holding the due cycle, the cycle in which reset must have risen, and the old and new gears. When a change restarts a flush in progress, the driver rewrites the pending entry instead of adding one. The monitor samples on the falling edge. It compares the cycle just before the due cycle against the old gear's settings and the due cycle itself against the new gear's settings. Whenever no entry is pending, it checks every cycle that the chain stays quiet.

// File: rtl/rbw_decim_pkg.sv
package rbw_decim_pkg;

  typedef enum logic {ST_RUN, ST_FLUSH} seq_state_e;

  // smallest r with 2**r >= v
  function automatic int ceil_log2(input int v);
    int r;
    r = 0;
    for (int i = 0; i < 31; i++) begin
      if ((1 << i) < v) r = i + 1;
    end
    return r;
  endfunction

  // bandwidth in Hz of a gear; gear num_gears-1 is the narrowest (rbw_min)
  function automatic longint gear_bw_hz(input int gear, input int num_gears,
                                        input int rbw_min);
    longint bw;
    int     steps;
    steps = num_gears - 1 - gear;
    bw    = longint'(rbw_min);
    for (int i = 0; i < 16; i++) begin
      if (i < steps / 2) bw = bw * 10;
    end
    if (steps % 2 == 1) bw = bw * 3;
    return bw;
  endfunction

endpackage

// File: rtl/rbw_gear_decode.sv
module rbw_gear_decode #(
  parameter int GEAR_W    = 3,
  parameter int CIC_W     = 10,
  parameter int HB_MAX    = 5,
  parameter int HB_CNT_W  = 3,
  parameter int CIC_ORDER = 5,
  parameter int SHIFT_W   = 6
) (
  input  logic [GEAR_W-1:0]   gear,
  output logic [CIC_W-1:0]    cic,
  output logic [HB_CNT_W-1:0] hb_cnt,
  output logic [HB_MAX-1:0]   hb_en,
  output logic [SHIFT_W-1:0]  shift
);
  import rbw_decim_pkg::*;

  // split of the total ratio between CIC and half-band depth
  always_comb begin
    case (int'(gear))
      0:       begin cic = CIC_W'(7);   hb_cnt = HB_CNT_W'(0); end
      1:       begin cic = CIC_W'(20);  hb_cnt = HB_CNT_W'(0); end
      2:       begin cic = CIC_W'(67);  hb_cnt = HB_CNT_W'(0); end
      3:       begin cic = CIC_W'(25);  hb_cnt = HB_CNT_W'(3); end
      4:       begin cic = CIC_W'(83);  hb_cnt = HB_CNT_W'(3); end
      5:       begin cic = CIC_W'(250); hb_cnt = HB_CNT_W'(3); end
      6:       begin cic = CIC_W'(208); hb_cnt = HB_CNT_W'(5); end
      default: begin cic = CIC_W'(625); hb_cnt = HB_CNT_W'(5); end
    endcase
  end

  // worst-case CIC bit growth, dropped so every gear lands at the same scale
  always_comb shift = SHIFT_W'(CIC_ORDER * ceil_log2(int'(cic)));

  // stages are used from the front of the cascade
  for (genvar i = 0; i < HB_MAX; i++) begin : g_hb_en
    assign hb_en[i] = (int'(hb_cnt) > i);
  end

endmodule

// File: rtl/rbw_flush_seq.sv
module rbw_flush_seq #(
  parameter int GEAR_W    = 3,
  parameter int FLUSH_CYC = 16,
  parameter int CNT_W     = $clog2(FLUSH_CYC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GEAR_W-1:0] gear_q,
  output logic [GEAR_W-1:0] act_gear,
  output logic              flushing
);
  import rbw_decim_pkg::*;

  seq_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [GEAR_W-1:0] tgt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_FLUSH;
      cnt      <= '0;
      tgt      <= '0;
      act_gear <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (gear_q != act_gear) begin
            state <= ST_FLUSH;
            tgt   <= gear_q;
            cnt   <= '0;
          end
        end
        default: begin
          if (gear_q != tgt) begin
            tgt <= gear_q;
            cnt <= '0;
          end else if (cnt == CNT_W'(FLUSH_CYC - 1)) begin
            state    <= ST_RUN;
            act_gear <= tgt;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign flushing = (state == ST_FLUSH);

  assert_flush_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FLUSH && gear_q != tgt) |=> (cnt == '0 && tgt == $past(gear_q)));

  assert_act_held_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |=> $stable(act_gear));

endmodule

// File: rtl/rbw_rate_monitor.sv
module rbw_rate_monitor #(
  parameter int GEAR_W     = 3,
  parameter int NUM_GEARS  = 8,
  parameter int CIC_W      = 10,
  parameter int HB_CNT_W   = 3,
  parameter int IN_RATE    = 100_000_000,
  parameter int RBW_MIN    = 1000,
  parameter int RATE_RATIO = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid,
  input  logic [GEAR_W-1:0]   gear,
  input  logic [CIC_W-1:0]    cic,
  input  logic [HB_CNT_W-1:0] hb_cnt,
  output logic                rate_err
);
  import rbw_decim_pkg::*;

  longint bw, prod, diff, lhs, rhs;

  always_comb begin
    bw   = gear_bw_hz(int'(gear), NUM_GEARS, RBW_MIN);
    prod = longint'(cic) << hb_cnt;
    diff = prod * longint'(RATE_RATIO) * bw - longint'(IN_RATE);
    if (diff < 0) diff = -diff;
    lhs  = 2 * diff;
    rhs  = (longint'(1) << hb_cnt) * longint'(RATE_RATIO) * bw;
  end

  always_ff @(posedge clk) begin
    if (rst) rate_err <= 1'b0;
    else     rate_err <= valid && (lhs > rhs);
  end

  assert_rate_product_R10: assert property (@(posedge clk) disable iff (rst)
    !rate_err);

endmodule

// File: rtl/rbw_decim_ctrl.sv
module rbw_decim_ctrl #(
  parameter int GEAR_IN_W  = 4,
  parameter int NUM_GEARS  = 8,
  parameter int GEAR_W     = $clog2(NUM_GEARS),
  parameter int CIC_W      = 10,
  parameter int HB_MAX     = 5,
  parameter int HB_CNT_W   = $clog2(HB_MAX + 1),
  parameter int CIC_ORDER  = 5,
  parameter int SHIFT_W    = 6,
  parameter int FLUSH_CYC  = 16,
  parameter int IN_RATE    = 100_000_000,
  parameter int RBW_MIN    = 1000,
  parameter int RATE_RATIO = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [GEAR_IN_W-1:0] gear_in,
  output logic [CIC_W-1:0]     cic_rate,
  output logic [HB_CNT_W-1:0]  hb_stages,
  output logic [HB_MAX-1:0]    hb_en,
  output logic [SHIFT_W-1:0]   cic_shift,
  output logic                 chain_rst,
  output logic                 cfg_valid,
  output logic                 rate_err
);

  localparam logic [GEAR_W-1:0] GEAR_TOP = GEAR_W'(NUM_GEARS - 1);

  logic [GEAR_W-1:0]   gear_lim, gear_q, act_gear, act_gear_q;
  logic                flushing;
  logic [CIC_W-1:0]    dec_cic;
  logic [HB_CNT_W-1:0] dec_hb_cnt;
  logic [HB_MAX-1:0]   dec_hb_en;
  logic [SHIFT_W-1:0]  dec_shift;

  always_comb begin
    if (gear_in > GEAR_IN_W'(NUM_GEARS - 1)) gear_lim = GEAR_TOP;
    else                                     gear_lim = gear_in[GEAR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) gear_q <= '0;
    else     gear_q <= gear_lim;
  end

  rbw_flush_seq #(
    .GEAR_W    (GEAR_W),
    .FLUSH_CYC (FLUSH_CYC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .gear_q   (gear_q),
    .act_gear (act_gear),
    .flushing (flushing)
  );

  rbw_gear_decode #(
    .GEAR_W    (GEAR_W),
    .CIC_W     (CIC_W),
    .HB_MAX    (HB_MAX),
    .HB_CNT_W  (HB_CNT_W),
    .CIC_ORDER (CIC_ORDER),
    .SHIFT_W   (SHIFT_W)
  ) u_dec (
    .gear   (act_gear),
    .cic    (dec_cic),
    .hb_cnt (dec_hb_cnt),
    .hb_en  (dec_hb_en),
    .shift  (dec_shift)
  );

  // output stage: settings and the handshake flags leave on the same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      chain_rst <= 1'b1;
      cfg_valid <= 1'b0;
    end else begin
      chain_rst <= flushing;
      cfg_valid <= !flushing;
    end
    cic_rate   <= dec_cic;
    hb_stages  <= dec_hb_cnt;
    hb_en      <= dec_hb_en;
    cic_shift  <= dec_shift;
    act_gear_q <= act_gear;
  end

  rbw_rate_monitor #(
    .GEAR_W     (GEAR_W),
    .NUM_GEARS  (NUM_GEARS),
    .CIC_W      (CIC_W),
    .HB_CNT_W   (HB_CNT_W),
    .IN_RATE    (IN_RATE),
    .RBW_MIN    (RBW_MIN),
    .RATE_RATIO (RATE_RATIO)
  ) u_mon (
    .clk      (clk),
    .rst      (rst),
    .valid    (cfg_valid),
    .gear     (act_gear_q),
    .cic      (cic_rate),
    .hb_cnt   (hb_stages),
    .rate_err (rate_err)
  );

  assert_cfg_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && $past(cfg_valid)) |->
      ($stable(cic_rate) && $stable(hb_stages) && $stable(hb_en) && $stable(cic_shift)));

  assert_clamp_R6: assert property (@(posedge clk) disable iff (rst)
    (gear_in > GEAR_IN_W'(NUM_GEARS - 1)) |=> (gear_q == GEAR_TOP));

  assert_rst_before_valid_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_valid) |-> $past(chain_rst));

  assert_hb_contig_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> ((hb_en & (hb_en + 1'b1)) == '0 && $countones(hb_en) == int'(hb_stages)));

endmodule

// File: tb/rbw_decim_ctrl_bench.sv
module rbw_decim_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int FL         = 16;
  localparam int WD_CYCLES  = 20000;

  typedef struct {
    int due;
    int rst_from;
    int gear;
    int prev;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] gear_in = 4'd0;
  logic [9:0] cic_rate;
  logic [2:0] hb_stages;
  logic [4:0] hb_en;
  logic [5:0] cic_shift;
  logic       chain_rst, cfg_valid, rate_err;

  int exp_cic[8]   = '{7, 20, 67, 25, 83, 250, 208, 625};
  int exp_hb[8]    = '{0, 0, 0, 3, 3, 3, 5, 5};
  int exp_en[8]    = '{0, 0, 0, 7, 7, 7, 31, 31};
  int exp_shift[8] = '{15, 25, 35, 25, 35, 40, 40, 50};

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_err = 0;
  int   tgt_model = 0;
  int   act_model = 0;
  int   last_rise = -1;
  bit   prev_rst = 1'b1;
  bit   armed = 1'b0;
  bit   done = 1'b0;

  rbw_decim_ctrl u_rbw_decim_ctrl (
    .clk       (clk),
    .rst       (rst),
    .gear_in   (gear_in),
    .cic_rate  (cic_rate),
    .hb_stages (hb_stages),
    .hb_en     (hb_en),
    .cic_shift (cic_shift),
    .chain_rst (chain_rst),
    .cfg_valid (cfg_valid),
    .rate_err  (rate_err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  function automatic string gear_req(input int g);
    if (g < 3)      return "R2";
    else if (g < 6) return "R3";
    else            return "R4";
  endfunction

  task automatic chk_settings(input int g, input string req);
    chk(int'(cic_rate) == exp_cic[g], req, "cic_rate", cic_rate, exp_cic[g]);
    chk(int'(hb_stages) == exp_hb[g], req, "hb_stages", hb_stages, exp_hb[g]);
    chk(int'(hb_en) == exp_en[g], req, "hb_en", hb_en, exp_en[g]);
    chk(int'(cic_shift) == exp_shift[g], "R5", "cic_shift", cic_shift, exp_shift[g]);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: present a raw code and predict the flush it causes
  task automatic apply(input int raw);
    int   cl;
    int   k;
    exp_t e;
    cl      = (raw > 7) ? 7 : raw;
    gear_in = 4'(raw);
    k       = cyc + 1;
    if (cl != tgt_model) begin
      if (q.size() > 0 && k < q[q.size()-1].due - 1) begin
        q[q.size()-1].due  = k + FL + 2;   // R9 restart
        q[q.size()-1].gear = cl;
      end else begin
        e.due      = k + FL + 2;
        e.rst_from = k + 2;
        e.gear     = cl;
        e.prev     = (q.size() > 0) ? q[q.size()-1].gear : act_model;
        q.push_back(e);
      end
      tgt_model = cl;
    end
  endtask

  task automatic settle();
    while (q.size() > 0) tick(1);
    tick(4);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (chain_rst && !prev_rst) last_rise = cyc;
      if (q.size() > 0) begin
        if (cyc == q[0].due - 1) begin
          chk(chain_rst == 1'b1, "R7", "chain_rst before apply", chain_rst, 1);
          chk(cfg_valid == 1'b0, "R7", "cfg_valid before apply", cfg_valid, 0);
          chk_settings(q[0].prev, "R8");
        end else if (cyc == q[0].due) begin
          chk(cfg_valid == 1'b1, "R7", "cfg_valid on apply", cfg_valid, 1);
          chk(chain_rst == 1'b0, "R7", "chain_rst on apply", chain_rst, 0);
          chk_settings(q[0].gear, gear_req(q[0].gear));
          if (q[0].rst_from >= 0)
            chk(last_rise == q[0].rst_from, "R9", "reset rise cycle", last_rise, q[0].rst_from);
          act_model = q[0].gear;
          armed     = 1'b1;
          void'(q.pop_front());
        end
      end else if (armed) begin
        chk(chain_rst == 1'b0 && cfg_valid == 1'b1, "R11", "quiet flags",
            {chain_rst, cfg_valid}, 1);
        chk(rate_err == 1'b0, "R10", "rate_err", rate_err, 0);
      end
    end
    prev_rst = chain_rst;
  end

  initial begin
    exp_t e;
    tick(5);
    // R1 reset state
    chk(chain_rst == 1'b1, "R1", "chain_rst in reset", chain_rst, 1);
    chk(cfg_valid == 1'b0, "R1", "cfg_valid in reset", cfg_valid, 0);
    chk_settings(0, "R1");
    rst = 1'b0;
    e.due = cyc + 1 + FL; e.rst_from = -1; e.gear = 0; e.prev = 0;
    q.push_back(e);
    settle();

    // R2 R3 R4 R5 every gear, R7 plain flush
    for (int g = 1; g < 8; g++) begin
      apply(g);
      settle();
    end
    apply(0); settle();
    apply(4); settle();

    // R11 same gear again
    apply(4); tick(25);

    // R6 clamp from another gear, then codes mapping to 7
    apply(12); settle();
    apply(15); tick(25);
    apply(7);  tick(10);
    apply(9);  tick(25);

    // R9 restart mid-flush
    apply(2); tick(5);
    apply(5); settle();
    // R9 change one cycle before the window would end: restart
    apply(1); tick(16);
    apply(6); settle();
    // change on the cycle the window ends: separate flush
    apply(3); tick(17);
    apply(0); settle();
    // change back to the active gear during a flush still flushes
    apply(6); tick(3);
    apply(0); settle();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not finish, actual %0d expected %0d", cyc, WD_CYCLES);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule